// File: doc/BRIEF.md
# In-order request-response window checker

This monitor watches a request strobe and a response strobe on one clock. Each request is owed a response of its own within a bounded latency window. Responses are credited strictly in arrival order. The oldest outstanding request takes the next response, and a response is never counted twice.

Every accepted request draws a ticket from an issue counter and records its issue time in a small queue. A second counter, the serving counter, names the request that the next response or timeout resolves. The serving counter advances on every verdict, pass or fail, so one late request does not block the requests behind it.

The monitor emits one single-cycle verdict per accepted request, in request order. It also keeps a sticky error flag and reports the number of outstanding requests.

Top module: `reqrsp_order_mon`

## Requirements
- R1: While reset is asserted and right after it is released, `pass_o`, `fail_o` and `err_o` are 0 and `outstanding_o` is 0.
- R2: The age of the oldest request at a clock edge is the number of edges since the edge that accepted it. A response sampled while that age lies in MIN_LAT..MAX_LAT (default 1..5) gives `pass_o`=1 for exactly the one cycle after that edge, and `outstanding_o` drops by one.
- R3: Each response is credited only to the oldest outstanding request. With requests at edges 1 and 3 and responses at edges 4 and 7, both requests pass. Two requests served by a single response give one pass and, later, one fail.
- R4: If the oldest request reaches age MAX_LAT with no response at that edge, `fail_o` is 1 for the cycle after that edge and the request is retired.
- R5: A response sampled while the oldest request's age is below MIN_LAT retires that request with `fail_o` and consumes the response.
- R6: A response sampled while no request is outstanding sets `err_o` and produces neither `pass_o` nor `fail_o`.
- R7: A request sampled while `outstanding_o` equals DEPTH (default 4) is dropped. It sets `err_o`, is not counted, and never receives a verdict.
- R8: When a request and a response are sampled at the same edge, the response goes to the request that was already outstanding. The new request is queued and cannot be matched by that response.
- R9: `err_o` is set by any fail, overflow or unexpected response, and only reset clears it.
- R10: `outstanding_o` equals accepted requests minus issued verdicts. At most one of `pass_o` and `fail_o` is 1 in any cycle.
- R11: A failed request still advances service, so the next request is judged against its own issue time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request strobe |
| rsp_i | input | 1 | Response strobe |
| pass_o | output | 1 | One-cycle pulse: oldest request passed |
| fail_o | output | 1 | One-cycle pulse: oldest request failed |
| err_o | output | 1 | Sticky error flag |
| outstanding_o | output | $clog2(DEPTH)+1 | Number of outstanding requests |

## Verification
Every result is registered once, so a verdict, an error or a change in the outstanding count appears one nanosecond after the edge that sampled the deciding response, request or timeout age. The bench drives a strobe just after an edge and holds it across the next edge. It samples the outputs 1 ns after that edge, then clears the strobe. Each check therefore lands in the single cycle in which the pulse is due. Idle edges at ages below the bound are also checked for the absence of a verdict. A second instance with MIN_LAT=2 makes the early-response failure reachable.

// File: rtl/rrm_pkg.sv
package rrm_pkg;
  typedef enum logic [1:0] {
    VERD_NONE = 2'd0,
    VERD_PASS = 2'd1,
    VERD_FAIL = 2'd2
  } verdict_e;
endpackage

// File: rtl/rrm_counter.sv
module rrm_counter #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/rrm_ts_fifo.sv
module rrm_ts_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/rrm_judge.sv
module rrm_judge
  import rrm_pkg::*;
#(
  parameter int MIN_LAT = 1,
  parameter int MAX_LAT = 5,
  parameter int TS_W    = 4
) (
  input  logic            head_vld_i,
  input  logic            rsp_i,
  input  logic [TS_W-1:0] age_i,
  output verdict_e        verdict_o
);
  always_comb begin
    verdict_o = VERD_NONE;
    if (head_vld_i) begin
      if (rsp_i)
        verdict_o = (age_i >= TS_W'(MIN_LAT)) ? VERD_PASS : VERD_FAIL;
      else if (age_i >= TS_W'(MAX_LAT))
        verdict_o = VERD_FAIL;
    end
  end
endmodule

// File: rtl/reqrsp_order_mon.sv
module reqrsp_order_mon
  import rrm_pkg::*;
#(
  parameter int MIN_LAT = 1,
  parameter int MAX_LAT = 5,
  parameter int DEPTH   = 4,
  localparam int AW     = $clog2(DEPTH),
  localparam int CW     = AW + 1,
  localparam int TS_W   = $clog2(MAX_LAT + 1) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          rsp_i,
  output logic          pass_o,
  output logic          fail_o,
  output logic          err_o,
  output logic [CW-1:0] outstanding_o
);
  logic [TS_W-1:0] now_q, head_ts, age;
  logic [CW-1:0]   tkt_q, srv_q, cnt;
  logic            head_vld, full, accept, resolve, unexp, ovf;
  verdict_e        verdict;

  rrm_counter #(.W(TS_W)) u_now (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(1'b1), .cnt_o(now_q)
  );

  // ticket: issue order; serving: next request to be resolved
  rrm_counter #(.W(CW)) u_ticket (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(accept), .cnt_o(tkt_q)
  );

  rrm_counter #(.W(CW)) u_serving (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(resolve), .cnt_o(srv_q)
  );

  assign cnt      = tkt_q - srv_q;
  assign head_vld = (cnt != '0);
  assign full     = (cnt == CW'(DEPTH));
  assign accept   = req_i && !full;
  assign ovf      = req_i && full;
  assign unexp    = rsp_i && !head_vld;

  rrm_ts_fifo #(.DEPTH(DEPTH), .W(TS_W)) u_fifo (
    .clk_i  (clk_i),
    .we_i   (accept),
    .waddr_i(tkt_q[AW-1:0]),
    .wdata_i(now_q),
    .raddr_i(srv_q[AW-1:0]),
    .rdata_o(head_ts)
  );

  assign age = now_q - head_ts;

  rrm_judge #(.MIN_LAT(MIN_LAT), .MAX_LAT(MAX_LAT), .TS_W(TS_W)) u_judge (
    .head_vld_i(head_vld),
    .rsp_i     (rsp_i),
    .age_i     (age),
    .verdict_o (verdict)
  );

  assign resolve = (verdict != VERD_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pass_o <= 1'b0;
      fail_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      pass_o <= (verdict == VERD_PASS);
      fail_o <= (verdict == VERD_FAIL);
      if ((verdict == VERD_FAIL) || ovf || unexp) err_o <= 1'b1;
    end
  end

  assign outstanding_o = cnt;
endmodule

// File: rtl/rrm_checker.sv
module rrm_checker #(
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          rsp_i,
  input logic          pass_o,
  input logic          fail_o,
  input logic          err_o,
  input logic [CW-1:0] outstanding_o
);
  AST_ONE_VERDICT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pass_o && fail_o)); // R10

  AST_OCC_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    outstanding_o <= CW'(DEPTH)); // R7

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R9

  AST_FAIL_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> err_o); // R9

  AST_UNEXP_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_i && outstanding_o == '0) |=> (err_o && !pass_o && !fail_o)); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && outstanding_o == CW'(DEPTH)) |=> err_o); // R7

  AST_VERDICT_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pass_o || fail_o) |-> ($past(outstanding_o) != '0)); // R10

  AST_PASS_NEEDS_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> $past(rsp_i)); // R2
endmodule

bind reqrsp_order_mon rrm_checker #(.DEPTH(DEPTH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .rsp_i        (rsp_i),
  .pass_o       (pass_o),
  .fail_o       (fail_o),
  .err_o        (err_o),
  .outstanding_o(outstanding_o)
);

// File: tb/reqrsp_order_mon_bench.sv
`timescale 1ns/1ps
module reqrsp_order_mon_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0, rsp = 1'b0, req2 = 1'b0, rsp2 = 1'b0;
  logic       pass, fail, err, pass2, fail2, err2;
  logic [2:0] outst, outst2;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  reqrsp_order_mon u_reqrsp_order_mon (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .rsp_i(rsp),
    .pass_o(pass), .fail_o(fail), .err_o(err), .outstanding_o(outst)
  );

  reqrsp_order_mon #(.MIN_LAT(2)) u_early (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req2), .rsp_i(rsp2),
    .pass_o(pass2), .fail_o(fail2), .err_o(err2), .outstanding_o(outst2)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    req = 0; rsp = 0; req2 = 0; rsp2 = 0;
    rst_n = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
  endtask

  // present strobes across one edge, sample 1 ns after it
  task automatic tick(input logic r, input logic s);
    req = r; rsp = s;
    @(posedge clk); #1;
    req = 0; rsp = 0;
  endtask

  task automatic tick2(input logic r, input logic s);
    req2 = r; rsp2 = s;
    @(posedge clk); #1;
    req2 = 0; rsp2 = 0;
  endtask

  task automatic t_reset();
    rst_n = 0;
    @(posedge clk); #1;
    chk("R1 pass in reset", pass, 0);
    chk("R1 err in reset", err, 0);
    do_reset();
    chk("R1 pass", pass, 0);
    chk("R1 fail", fail, 0);
    chk("R1 err", err, 0);
    chk("R1 outstanding", outst, 0);
  endtask

  task automatic t_pass();
    do_reset();
    tick(1, 0);
    chk("R10 outstanding after req", outst, 1);
    tick(0, 0); tick(0, 0);
    chk("R2 no early verdict", pass | fail, 0);
    tick(0, 1);
    chk("R2 pass age3", pass, 1);
    chk("R2 no fail age3", fail, 0);
    chk("R10 outstanding after pass", outst, 0);
    tick(0, 0);
    chk("R2 pass pulse width", pass, 0);
    tick(1, 0); tick(0, 1);
    chk("R2 pass age1", pass, 1);
    tick(1, 0);
    for (int i = 0; i < 4; i++) begin
      tick(0, 0);
      chk("R4 no timeout before bound", fail, 0);
    end
    tick(0, 1);
    chk("R2 pass age5", pass, 1);
    chk("R9 err clear after passes", err, 0);
  endtask

  task automatic t_order();
    do_reset();
    tick(1, 0); tick(0, 0); tick(1, 0);
    tick(0, 1);
    chk("R3 first pass", pass, 1);
    chk("R3 outstanding", outst, 1);
    tick(0, 0); tick(0, 0);
    chk("R3 no verdict between", pass | fail, 0);
    tick(0, 1);
    chk("R3 second pass", pass, 1);
    chk("R3 no error", err, 0);
  endtask

  task automatic t_shared_rsp();
    do_reset();
    tick(1, 0); tick(1, 0);
    tick(0, 1);
    chk("R3 first of two passes", pass, 1);
    for (int i = 0; i < 3; i++) begin
      tick(0, 0);
      chk("R3 second waits", fail, 0);
    end
    tick(0, 0);
    chk("R3 second fails on timeout", fail, 1);
    chk("R4 err after timeout", err, 1);
    chk("R10 outstanding drained", outst, 0);
  endtask

  task automatic t_timeout();
    do_reset();
    tick(1, 0); tick(0, 0); tick(1, 0);
    tick(0, 0); tick(0, 0);
    chk("R4 no fail at age4", fail, 0);
    tick(0, 0);
    chk("R4 fail at age5", fail, 1);
    chk("R10 outstanding after fail", outst, 1);
    tick(0, 1);
    chk("R11 next request passes", pass, 1);
    chk("R11 no second fail", fail, 0);
  endtask

  task automatic t_same_cycle();
    do_reset();
    tick(1, 0);
    tick(1, 1);
    chk("R8 rsp to older request", pass, 1);
    chk("R8 new request queued", outst, 1);
    tick(0, 0);
    chk("R8 new request not matched", pass | fail, 0);
    tick(0, 1);
    chk("R8 new request passes later", pass, 1);
    chk("R8 no error", err, 0);
    do_reset();
    tick(1, 1);
    chk("R8 empty queue rsp unexpected", err, 1);
    chk("R8 no pass on empty", pass, 0);
    chk("R8 request still queued", outst, 1);
  endtask

  task automatic t_unexp();
    do_reset();
    tick(0, 1);
    chk("R6 err set", err, 1);
    chk("R6 no pass", pass, 0);
    chk("R6 no fail", fail, 0);
    chk("R6 outstanding", outst, 0);
    tick(1, 0); tick(0, 1);
    chk("R9 pass keeps err", err, 1);
    tick(0, 0);
    chk("R9 err sticky", err, 1);
    do_reset();
    chk("R9 reset clears err", err, 0);
  endtask

  task automatic t_overflow();
    do_reset();
    for (int i = 0; i < 4; i++) tick(1, 0);
    chk("R7 full", outst, 4);
    chk("R7 no err when full", err, 0);
    tick(1, 0);
    chk("R7 overflow err", err, 1);
    chk("R7 dropped request", outst, 4);
    for (int i = 0; i < 4; i++) begin
      tick(0, 1);
      chk("R7 queued request passes", pass, 1);
    end
    chk("R7 queue empty", outst, 0);
    tick(0, 1);
    chk("R7 dropped gets no verdict", pass | fail, 0);
  endtask

  task automatic t_early();
    do_reset();
    tick2(1, 0);
    tick2(0, 1);
    chk("R5 early fail", fail2, 1);
    chk("R5 no pass", pass2, 0);
    chk("R5 response consumed", outst2, 0);
    chk("R5 err", err2, 1);
    tick2(1, 0); tick2(0, 0); tick2(0, 1);
    chk("R5 pass at lower bound", pass2, 1);
  endtask

  initial begin
    t_reset();
    t_pass();
    t_order();
    t_shared_rsp();
    t_timeout();
    t_same_cycle();
    t_unexp();
    t_overflow();
    t_early();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule